// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block sits between a bank of GPIO pads and the peripheral logic of a chip. Each pad has two byte-wide selectors: one picks the source of the pad's output level, the other picks the source of its output enable. Both choose from a constant or from one line of a vector of internal signals. Each peripheral input line has its own byte-wide selector. That selector picks a pad, a constant 0 or a constant 1. A pad is encoded as its number plus two, so the two lowest codes stay free for the constants.

Software programs the selectors over a simple 32-bit register port. The port has a write strobe, byte enables, a byte address and a read data bus that is valid in the same cycle as the address. Each word holds four selectors. A read-only bank reports the live level of every pad, one bit per pad. The routing paths are purely combinational from the selected sources. A register write changes the routing starting with the cycle after the write edge.

Top module: `gxbar_top`

## Requirements
- R1: After reset, every pad output selector holds 0 (constant low), every enable selector holds 1 (forced disable), and every peripheral input selector holds 0 (constant 0). Reads return 0x00000000, 0x01010101 and 0x00000000 in those banks.
- R2: The selector for index n sits in the word at bank base + 4*(n/4), at bits 8*(n%4) upward. The bank bases are 0x00 for pad output, 0x40 for pad enable and 0x80 for peripheral input.
- R3: A write updates only the lanes whose byte enable is set. The other lanes of the word keep their values.
- R4: Output selector code 0 drives the pad low and code 1 drives it high. Code k+2 drives it from internal output k. A code naming no internal output drives 0. All 8 bits of the lane are significant.
- R5: Enable selector code 0 forces the pad enable on and code 1 forces it off. Code k+2 follows internal enable k. A code naming no internal enable gives 0.
- R6: The enable lane keeps only its low 6 bits. The upper 2 bits of a written byte are dropped and read back as 0.
- R7: Input selector code 0 gives constant 0 and code 1 gives constant 1. Code p+2 routes pad p. A code naming no pad gives 0. Reading the selector back returns the written code.
- R8: The read-only level bank at 0xC0 returns the live level of pad p in word 0xC0 + 4*(p/32), bit p%32.
- R9: Pad outputs, pad enables and peripheral inputs follow their selected sources in the same cycle. A selector write takes effect only after the clock edge that captures it.
- R10: Addresses outside the three selector banks and the level bank read as 0. A write to them, including a write to the level bank, changes no selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address; bits 1:0 ignored |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| core_out | input | 32 | Internal output signals selectable onto pads |
| core_oe | input | 32 | Internal enable signals selectable onto pads |
| pad_in | input | 16 | Live pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| periph_in | output | 16 | Routed peripheral input lines |

## Verification
A corrupted selector shows up at once. The affected pad or peripheral line starts following the wrong source, and a read of that word returns the bad code in the same cycle as the address. The read path and the routing path share the same stored selectors. So the bench compares readback against a model and also drives distinct patterns on core_out, core_oe and pad_in. This lets it tell apart codes that differ by one, such as the pad+2 offset and the constant codes. A write that touches a neighbouring lane or lands one cycle early is visible one edge after the write.

// File: rtl/gxbar_pkg.sv
package gxbar_pkg;
    localparam int LANE_W      = 8;   // byte lane per selector
    localparam int OE_SEL_W    = 6;   // significant bits of an enable lane
    localparam int SRC_OFFSET  = 2;   // first code that names a real source
    localparam int OUT_LOW     = 0;
    localparam int OUT_HIGH    = 1;
    localparam int OE_ON       = 0;
    localparam int OE_OFF      = 1;
    localparam int IN_ZERO     = 0;
    localparam int IN_ONE      = 1;
endpackage

// File: rtl/gxbar_cfg_regs.sv
module gxbar_cfg_regs
    import gxbar_pkg::*;
#(
    parameter int NUM_PADS   = 16,
    parameter int NUM_PERIPH = 16,
    parameter int ADDR_W     = 8,
    parameter int OUT_BASE   = 'h00,
    parameter int OE_BASE    = 'h40,
    parameter int IN_BASE    = 'h80,
    parameter int LVL_BASE   = 'hC0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [3:0]                            be,
    input  logic [31:0]                           wdata,
    input  logic [NUM_PADS-1:0]                   pad_in,
    output logic [31:0]                           rdata,
    output logic [NUM_PADS-1:0][LANE_W-1:0]       osel,
    output logic [NUM_PADS-1:0][OE_SEL_W-1:0]     oesel,
    output logic [NUM_PERIPH-1:0][LANE_W-1:0]     isel
);
    localparam int OUT_WB = OUT_BASE / 4;
    localparam int OE_WB  = OE_BASE / 4;
    localparam int IN_WB  = IN_BASE / 4;
    localparam int LVL_WB = LVL_BASE / 4;

    typedef struct packed {
        logic [NUM_PADS-1:0][LANE_W-1:0]   osel;
        logic [NUM_PADS-1:0][OE_SEL_W-1:0] oesel;
        logic [NUM_PERIPH-1:0][LANE_W-1:0] isel;
    } cfg_t;

    cfg_t cfg_d, cfg_q, cfg_rst;
    int   word_idx;

    assign word_idx = int'(addr[ADDR_W-1:2]);

    always_comb begin
        cfg_rst = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            cfg_rst.osel[p]  = LANE_W'(OUT_LOW);
            cfg_rst.oesel[p] = OE_SEL_W'(OE_OFF);
        end
        for (int i = 0; i < NUM_PERIPH; i++) begin
            cfg_rst.isel[i] = LANE_W'(IN_ZERO);
        end
    end

    // next-state: byte-lane writes, untouched lanes keep their value
    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (word_idx == OUT_WB + p / 4 && be[p % 4])
                    cfg_d.osel[p] = wdata[8*(p%4) +: LANE_W];
                if (word_idx == OE_WB + p / 4 && be[p % 4])
                    cfg_d.oesel[p] = wdata[8*(p%4) +: OE_SEL_W];
            end
            for (int i = 0; i < NUM_PERIPH; i++) begin
                if (word_idx == IN_WB + i / 4 && be[i % 4])
                    cfg_d.isel[i] = wdata[8*(i%4) +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_rst;
        else        cfg_q <= cfg_d;
    end

    // read mux, unmapped words return zero
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (word_idx == OUT_WB + p / 4)
                rdata[8*(p%4) +: LANE_W] = cfg_q.osel[p];
            if (word_idx == OE_WB + p / 4)
                rdata[8*(p%4) +: LANE_W] = {{(LANE_W-OE_SEL_W){1'b0}}, cfg_q.oesel[p]};
            if (word_idx == LVL_WB + p / 32)
                rdata[p%32] = pad_in[p];
        end
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (word_idx == IN_WB + i / 4)
                rdata[8*(i%4) +: LANE_W] = cfg_q.isel[i];
        end
    end

    assign osel  = cfg_q.osel;
    assign oesel = cfg_q.oesel;
    assign isel  = cfg_q.isel;
endmodule

// File: rtl/gxbar_pad_route.sv
module gxbar_pad_route
    import gxbar_pkg::*;
#(
    parameter int NUM_PADS     = 16,
    parameter int NUM_CORE_OUT = 32,
    parameter int NUM_CORE_OE  = 32
) (
    input  logic [NUM_PADS-1:0][LANE_W-1:0]   osel,
    input  logic [NUM_PADS-1:0][OE_SEL_W-1:0] oesel,
    input  logic [NUM_CORE_OUT-1:0]           core_out,
    input  logic [NUM_CORE_OE-1:0]            core_oe,
    output logic [NUM_PADS-1:0]               pad_out,
    output logic [NUM_PADS-1:0]               pad_oe
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        always_comb begin
            pad_out[p] = 1'b0;
            if (int'(osel[p]) == OUT_HIGH) pad_out[p] = 1'b1;
            for (int k = 0; k < NUM_CORE_OUT; k++) begin
                if (int'(osel[p]) == k + SRC_OFFSET) pad_out[p] = core_out[k];
            end
        end
        always_comb begin
            pad_oe[p] = 1'b0;
            if (int'(oesel[p]) == OE_ON) pad_oe[p] = 1'b1;
            for (int k = 0; k < NUM_CORE_OE; k++) begin
                if (int'(oesel[p]) == k + SRC_OFFSET) pad_oe[p] = core_oe[k];
            end
        end
    end
endmodule

// File: rtl/gxbar_periph_route.sv
module gxbar_periph_route
    import gxbar_pkg::*;
#(
    parameter int NUM_PADS   = 16,
    parameter int NUM_PERIPH = 16
) (
    input  logic [NUM_PERIPH-1:0][LANE_W-1:0] isel,
    input  logic [NUM_PADS-1:0]               pad_in,
    output logic [NUM_PERIPH-1:0]             periph_in
);
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_in
        always_comb begin
            periph_in[i] = 1'b0;
            if (int'(isel[i]) == IN_ONE) periph_in[i] = 1'b1;
            for (int p = 0; p < NUM_PADS; p++) begin
                if (int'(isel[i]) == p + SRC_OFFSET) periph_in[i] = pad_in[p];
            end
        end
    end
endmodule

// File: rtl/gxbar_top.sv
module gxbar_top
    import gxbar_pkg::*;
#(
    parameter int NUM_PADS     = 16,
    parameter int NUM_CORE_OUT = 32,
    parameter int NUM_CORE_OE  = 32,
    parameter int NUM_PERIPH   = 16,
    parameter int ADDR_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [3:0]              reg_be,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_CORE_OUT-1:0] core_out,
    input  logic [NUM_CORE_OE-1:0]  core_oe,
    input  logic [NUM_PADS-1:0]     pad_in,
    output logic [NUM_PADS-1:0]     pad_out,
    output logic [NUM_PADS-1:0]     pad_oe,
    output logic [NUM_PERIPH-1:0]   periph_in
);
    logic [NUM_PADS-1:0][LANE_W-1:0]   osel_w;
    logic [NUM_PADS-1:0][OE_SEL_W-1:0] oesel_w;
    logic [NUM_PERIPH-1:0][LANE_W-1:0] isel_w;

    gxbar_cfg_regs #(
        .NUM_PADS(NUM_PADS), .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .be(reg_be),
        .wdata(reg_wdata), .pad_in(pad_in), .rdata(reg_rdata),
        .osel(osel_w), .oesel(oesel_w), .isel(isel_w)
    );

    gxbar_pad_route #(
        .NUM_PADS(NUM_PADS), .NUM_CORE_OUT(NUM_CORE_OUT), .NUM_CORE_OE(NUM_CORE_OE)
    ) u_pad (
        .osel(osel_w), .oesel(oesel_w), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gxbar_periph_route #(
        .NUM_PADS(NUM_PADS), .NUM_PERIPH(NUM_PERIPH)
    ) u_periph (
        .isel(isel_w), .pad_in(pad_in), .periph_in(periph_in)
    );
endmodule

// File: rtl/gxbar_chk.sv
module gxbar_chk
    import gxbar_pkg::*;
#(
    parameter int NUM_PADS   = 16,
    parameter int NUM_PERIPH = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_we,
    input logic [3:0]                          reg_be,
    input logic [NUM_PADS-1:0][LANE_W-1:0]     osel,
    input logic [NUM_PADS-1:0][OE_SEL_W-1:0]   oesel,
    input logic [NUM_PERIPH-1:0][LANE_W-1:0]   isel,
    input logic [NUM_PADS-1:0]                 pad_out,
    input logic [NUM_PADS-1:0]                 pad_oe,
    input logic [NUM_PERIPH-1:0]               periph_in
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
        AST_OUT_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(osel[p]) == OUT_HIGH) |-> pad_out[p]);                 // R4
        AST_OUT_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(osel[p]) == OUT_LOW) |-> !pad_out[p]);                 // R4
        AST_OE_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(oesel[p]) == OE_ON) |-> pad_oe[p]);                    // R5
        AST_OE_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(oesel[p]) == OE_OFF) |-> !pad_oe[p]);                  // R5
        AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_be[p % 4]) |=> ($stable(osel[p]) && $stable(oesel[p]))); // R3
    end
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_in_chk
        AST_IN_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(isel[i]) == IN_ONE) |-> periph_in[i]);                 // R7
        AST_IN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_be[i % 4]) |=> $stable(isel[i]));            // R3
    end
endmodule

bind gxbar_top gxbar_chk #(.NUM_PADS(NUM_PADS), .NUM_PERIPH(NUM_PERIPH)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
    .osel(osel_w), .oesel(oesel_w), .isel(isel_w),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_in(periph_in)
);

// File: tb/test_gxbar_top.sv
module test_gxbar_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int NO = 32;
    localparam int NE = 32;
    localparam int NI = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [3:0]    reg_be = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NO-1:0] core_out = '0;
    logic [NE-1:0] core_oe = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NI-1:0] periph_in;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gxbar_top i_gxbar_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_in(periph_in)
    );

    // reference model of the selectors, built from the requirements
    logic [7:0] m_osel  [NP];
    logic [5:0] m_oesel [NP];
    logic [7:0] m_isel  [NI];

    typedef struct {
        string       req;
        int          kind;   // 0 rdata, 1 pad_out, 2 pad_oe, 3 periph_in
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        int w = int'(a[7:2]);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            if (w < 4)                 r[8*b +: 8] = m_osel[w*4+b];
            if (w >= 16 && w < 20)     r[8*b +: 8] = {2'b00, m_oesel[(w-16)*4+b]};
            if (w >= 32 && w < 36)     r[8*b +: 8] = m_isel[(w-32)*4+b];
        end
        if (w == 48) r = {16'h0, pad_in};
        return r;
    endfunction

    function automatic logic [31:0] exp_route(int kind);
        logic [31:0] r = '0;
        int c;
        for (int n = 0; n < 16; n++) begin
            if (kind == 1) begin
                c = int'(m_osel[n]);
                r[n] = (c == 1) ? 1'b1 : (c >= 2 && c < NO + 2) ? core_out[c-2] : 1'b0;
            end else if (kind == 2) begin
                c = int'(m_oesel[n]);
                r[n] = (c == 0) ? 1'b1 : (c >= 2 && c < NE + 2) ? core_oe[c-2] : 1'b0;
            end else begin
                c = int'(m_isel[n]);
                r[n] = (c == 1) ? 1'b1 : (c >= 2 && c < NP + 2) ? pad_in[c-2] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic push(string req, int kind);
        item_t it;
        it.req  = req;
        it.kind = kind;
        it.exp  = (kind == 0) ? exp_rd(reg_addr) : exp_route(kind);
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // monitor: pops expectations and compares against the live ports
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {16'h0, pad_out};
                2:       act = {16'h0, pad_oe};
                default: act = {16'h0, periph_in};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic model_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        int w = int'(a[7:2]);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                if (w < 4)             m_osel[w*4+b]        = d[8*b +: 8];
                if (w >= 16 && w < 20) m_oesel[(w-16)*4+b]  = d[8*b +: 6];
                if (w >= 32 && w < 36) m_isel[(w-32)*4+b]   = d[8*b +: 8];
            end
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        model_wr(a, d, be);
    endtask

    task automatic chk_rd(string req, logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        push(req, 0);
    endtask

    task automatic chk_route(string req);
        @(negedge clk);
        #1;
        push(req, 1);
        push(req, 2);
        push(req, 3);
    endtask

    initial begin
        for (int n = 0; n < NP; n++) begin m_osel[n] = 8'd0; m_oesel[n] = 6'd1; end
        for (int n = 0; n < NI; n++) m_isel[n] = 8'd0;
        core_out = 32'hA5C3_0F96;
        core_oe  = 32'h3C5A_F00F;
        pad_in   = 16'hB4E1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1", 8'h00);
        chk_rd("R1", 8'h44);
        chk_rd("R1", 8'h8C);
        chk_route("R1");

        // R2 lane layout: pads 4..7 from word 0x04
        bus_wr(8'h04, 32'h0504_0302, 4'hF);
        chk_rd("R2", 8'h04);
        chk_route("R2");

        // R3 single-lane write keeps neighbours
        bus_wr(8'h04, 32'hFFFF_01FF, 4'b0010);
        chk_rd("R3", 8'h04);
        bus_wr(8'h84, 32'h1111_2222, 4'b1000);
        chk_rd("R3", 8'h84);

        // R4 output codes: high, last source, out of range, max code
        bus_wr(8'h00, 32'hFF22_2101, 4'hF);
        chk_rd("R4", 8'h00);
        chk_route("R4");
        core_out = 32'h5A3C_F069;
        chk_route("R4");

        // R5 enable codes and R6 upper bits dropped
        bus_wr(8'h40, 32'hC022_0300, 4'hF);
        chk_rd("R6", 8'h40);
        chk_route("R5");
        core_oe = ~core_oe;
        chk_route("R5");
        bus_wr(8'h44, 32'h2223_C1FF, 4'hF);
        chk_rd("R6", 8'h44);
        chk_route("R6");

        // R7 input codes: const 0, const 1, pad 0, pad 15, no pad
        bus_wr(8'h80, 32'h1102_0100, 4'hF);
        bus_wr(8'h88, 32'h0000_0012, 4'b0001);
        chk_rd("R7", 8'h80);
        chk_rd("R7", 8'h88);
        chk_route("R7");
        pad_in = 16'h4B1E;
        chk_route("R7");

        // R8 live level bank
        chk_rd("R8", 8'hC0);
        pad_in = 16'h8001;
        chk_rd("R8", 8'hC0);

        // R9 same-cycle routing, write effective after the edge
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0000_0001; reg_be = 4'b0001;
        #1;
        push("R9", 1);
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        model_wr(8'h08, 32'h0000_0001, 4'b0001);
        push("R9", 1);
        core_out = ~core_out;
        #1;
        push("R9", 1);

        // R10 unmapped and read-only writes
        bus_wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'hC0, 32'hFFFF_FFFF, 4'hF);
        chk_rd("R10", 8'h30);
        chk_rd("R10", 8'h00);
        chk_rd("R10", 8'h40);
        chk_route("R10");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule